// File: doc/BRIEF.md
# Multi-Mode Status Register Bank

This block is a small bank of software-visible registers that sits between hardware event sources and a simple synchronous register bus. Each register word is given one access mode by a compile-time map. The mode decides how the word's bits follow their hardware input:

- sampled one cycle late;
- passed straight to the read path;
- held on a level;
- captured on an edge;
- written by software as interrupt enables;
- written by software to fire one-cycle strobes;
- loaded once from hardware just after reset, then owned by software.

Status words can be cleared in one of two ways. Some clear when software reads them. Others keep their value until software writes a one-mask to them.

Every edge-capture bit is gated by the enable register at the same bit position. The gated bits are ORed together to form a single registered interrupt line.

A read returns data on `bus_rdata` one cycle after the read request. A read or mask-write clear and a new hardware set condition can fall in the same cycle. In that case the set takes priority, so no event is lost.

All inputs are assumed synchronous to `clk`.

Top module: `stat_bank`

## Requirements
- R1: A sampled word (mode code 0) registers its hardware input every cycle, so a read returns the input value from one cycle before the read cycle. Bus writes to it have no effect.
- R2: A pass-through word (mode code 1) has no storage. A read returns the hardware input present in the read cycle.
- R3: A level clear-on-read word sets each bit while its input is high (mode 2) or low (mode 3). The bit stays set until the word is read. A read returns the value before the clear. A set condition in the read cycle survives the clear.
- R4: A level mask-clear word (mode 4 high, mode 5 low) sets like R3 and ignores reads. A write clears exactly the bits written as 1 and leaves bits written as 0 unchanged. A set in the write cycle survives the clear.
- R5: An edge clear-on-read word captures a 0-to-1 change (mode 6) or a 1-to-0 change (mode 7) of each input bit, measured against the previous cycle. A read clears it, and a held input level does not set it again.
- R6: An edge mask-clear word (mode 8 rising, mode 9 falling) captures like R5, is unchanged by reads, and is cleared by written ones.
- R7: An enable word (mode 10) is written from the bus and reads back as written. Its value also appears on its slice of `hw_ctl`.
- R8: A strobe word (mode 11) stores and reads back the written value. Its `hw_ctl` slice carries the written data for exactly the one cycle after the write and is zero at all other times.
- R9: A load-after-reset word (mode 12) takes its hardware input on the first clock edge after reset is released. After that, bus writes set it. Its value appears on its `hw_ctl` slice.
- R10: `irq_o` is the registered OR, over every edge-capture word, of each status bit ANDed with the enable bit at the same position. It follows the status by one cycle.
- R11: `bus_rdata` updates only on the edge where `bus_ren` is high, and holds its value otherwise. Addresses with no register read as zero.
- R12: While reset is high, all stored bits, `bus_rdata`, `irq_o` and every `hw_ctl` slice are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Word address for read or write |
| bus_wdata | input | DW | Write data or clear mask |
| bus_wen | input | 1 | Write request for this cycle |
| bus_ren | input | 1 | Read request for this cycle |
| bus_rdata | output | DW | Read data, valid the cycle after `bus_ren` |
| hw_in | input | NREG*DW | Hardware inputs, word g at bits g*DW upward |
| hw_ctl | output | NREG*DW | Hardware controls: enables, strobes and load-after-reset values |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check four properties on every cycle:

- a pass-through read returns the live input;
- read data holds when no read is requested, and unmapped addresses read as zero;
- an enable write appears on its control slice at once;
- a strobe is high only in the cycle after a write to its word, and carries the written data.

They also check that the interrupt line stays low whenever no enable bit is set.

Some behaviours depend on a history of hardware stimulus and clears that no single-cycle property captures, so only the bench scenarios show them:

- the set-over-clear priority;
- that a held level does not re-arm an edge bit;
- the one-cycle lag of sampled words;
- the single load after reset;
- the extra cycle of interrupt latency.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;

  typedef enum logic [3:0] {
    FM_RO        = 4'd0,
    FM_RV        = 4'd1,
    FM_LVL_HI_RC = 4'd2,
    FM_LVL_LO_RC = 4'd3,
    FM_LVL_HI_WC = 4'd4,
    FM_LVL_LO_WC = 4'd5,
    FM_EDG_UP_RC = 4'd6,
    FM_EDG_DN_RC = 4'd7,
    FM_EDG_UP_WC = 4'd8,
    FM_EDG_DN_WC = 4'd9,
    FM_IEN       = 4'd10,
    FM_STRB      = 4'd11,
    FM_LOR       = 4'd12
  } fmode_e;

  function automatic bit is_edge(fmode_e m);
    return (m == FM_EDG_UP_RC) || (m == FM_EDG_DN_RC) ||
           (m == FM_EDG_UP_WC) || (m == FM_EDG_DN_WC);
  endfunction

  function automatic bit is_level(fmode_e m);
    return (m == FM_LVL_HI_RC) || (m == FM_LVL_LO_RC) ||
           (m == FM_LVL_HI_WC) || (m == FM_LVL_LO_WC);
  endfunction

  function automatic bit clears_on_read(fmode_e m);
    return (m == FM_LVL_HI_RC) || (m == FM_LVL_LO_RC) ||
           (m == FM_EDG_UP_RC) || (m == FM_EDG_DN_RC);
  endfunction

endpackage

// File: rtl/sb_field.sv
module sb_field #(
  parameter int                    DW   = 8,
  parameter stat_bank_pkg::fmode_e MODE = stat_bank_pkg::FM_RO
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] hw_i,
  input  logic          hit_wr,
  input  logic          hit_rd,
  input  logic [DW-1:0] wdata,
  input  logic          load_now,
  output logic [DW-1:0] rd_o,
  output logic [DW-1:0] ctl_o,
  output logic [DW-1:0] src_o,
  output logic [DW-1:0] ien_o
);
  import stat_bank_pkg::*;

  localparam bit IS_EDG  = is_edge(MODE);
  localparam bit IS_LVL  = is_level(MODE);
  localparam bit RD_CLR  = clears_on_read(MODE);
  localparam bit ACT_LOW = (MODE == FM_LVL_LO_RC) || (MODE == FM_LVL_LO_WC);
  localparam bit RISING  = (MODE == FM_EDG_UP_RC) || (MODE == FM_EDG_UP_WC);
  localparam bit SW_OWN  = (MODE == FM_IEN) || (MODE == FM_STRB) || (MODE == FM_LOR);

  logic [DW-1:0] q, prev, stb;
  logic [DW-1:0] nxt, set_v, clr_v;

  // Set and clear terms; the set is ORed in after the clear so it wins.
  always_comb begin
    if (IS_EDG)
      set_v = RISING ? (hw_i & ~prev) : (~hw_i & prev);
    else
      set_v = ACT_LOW ? ~hw_i : hw_i;

    if (RD_CLR)
      clr_v = {DW{hit_rd}};
    else
      clr_v = hit_wr ? wdata : '0;

    nxt = q;
    if (MODE == FM_RO)
      nxt = hw_i;
    else if (IS_LVL || IS_EDG)
      nxt = (q & ~clr_v) | set_v;
    else if ((MODE == FM_LOR) && load_now)
      nxt = hw_i;
    else if (SW_OWN && hit_wr)
      nxt = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      prev <= '0;
      stb  <= '0;
    end else begin
      q    <= nxt;
      prev <= hw_i;
      stb  <= ((MODE == FM_STRB) && hit_wr) ? wdata : '0;
    end
  end

  assign rd_o  = (MODE == FM_RV) ? hw_i : q;
  assign ctl_o = (MODE == FM_STRB) ? stb :
                 ((MODE == FM_IEN) || (MODE == FM_LOR)) ? q : '0;
  assign src_o = IS_EDG ? q : '0;
  assign ien_o = (MODE == FM_IEN) ? q : '0;

endmodule

// File: rtl/sb_rd_mux.sv
module sb_rd_mux #(
  parameter int DW   = 8,
  parameter int NREG = 13,
  parameter int AW   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ren,
  input  logic [AW-1:0]            addr,
  input  logic [NREG-1:0][DW-1:0]  vals,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == AW'(i)) sel = vals[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      rdata <= '0;
    else if (ren) rdata <= sel;
  end

endmodule

// File: rtl/sb_irq.sv
module sb_irq #(
  parameter int DW   = 8,
  parameter int NREG = 13
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NREG-1:0][DW-1:0] src,
  input  logic [NREG-1:0][DW-1:0] en,
  output logic                    irq
);
  logic [DW-1:0] pend, ena;

  always_comb begin
    pend = '0;
    ena  = '0;
    for (int i = 0; i < NREG; i++) begin
      pend = pend | src[i];
      ena  = ena  | en[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(pend & ena);
  end

endmodule

// File: rtl/stat_bank.sv
module stat_bank #(
  parameter int               DW       = 8,
  parameter int               NREG     = 13,
  parameter int               AW       = 4,
  parameter logic [4*NREG-1:0] MODE_MAP = 52'hC_BA98_7654_3210
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  input  logic               bus_wen,
  input  logic               bus_ren,
  output logic [DW-1:0]      bus_rdata,
  input  logic [NREG*DW-1:0] hw_in,
  output logic [NREG*DW-1:0] hw_ctl,
  output logic               irq_o
);
  import stat_bank_pkg::*;

  logic armed_q;
  logic [NREG-1:0][DW-1:0] rd_vals, src_vals, en_vals, ctl_vals;

  // Low only during the first cycle after reset is released.
  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= 1'b1;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_word
    localparam fmode_e M = fmode_e'(MODE_MAP[4*g +: 4]);
    logic hit_wr, hit_rd;
    assign hit_wr = bus_wen && (bus_addr == AW'(g));
    assign hit_rd = bus_ren && (bus_addr == AW'(g));

    sb_field #(.DW(DW), .MODE(M)) u_fld (
      .clk      (clk),
      .rst      (rst),
      .hw_i     (hw_in[g*DW +: DW]),
      .hit_wr   (hit_wr),
      .hit_rd   (hit_rd),
      .wdata    (bus_wdata),
      .load_now (~armed_q),
      .rd_o     (rd_vals[g]),
      .ctl_o    (ctl_vals[g]),
      .src_o    (src_vals[g]),
      .ien_o    (en_vals[g])
    );

    assign hw_ctl[g*DW +: DW] = ctl_vals[g];
  end

  sb_rd_mux #(.DW(DW), .NREG(NREG), .AW(AW)) u_mux (
    .clk   (clk),
    .rst   (rst),
    .ren   (bus_ren),
    .addr  (bus_addr),
    .vals  (rd_vals),
    .rdata (bus_rdata)
  );

  sb_irq #(.DW(DW), .NREG(NREG)) u_irq (
    .clk (clk),
    .rst (rst),
    .src (src_vals),
    .en  (en_vals),
    .irq (irq_o)
  );

endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk #(
  parameter int               DW       = 8,
  parameter int               NREG     = 13,
  parameter int               AW       = 4,
  parameter logic [4*NREG-1:0] MODE_MAP = 52'hC_BA98_7654_3210
) (
  input logic               clk,
  input logic               rst,
  input logic [AW-1:0]      bus_addr,
  input logic [DW-1:0]      bus_wdata,
  input logic               bus_wen,
  input logic               bus_ren,
  input logic [DW-1:0]      bus_rdata,
  input logic [NREG*DW-1:0] hw_in,
  input logic [NREG*DW-1:0] hw_ctl,
  input logic               irq_o
);
  import stat_bank_pkg::*;

  logic [DW-1:0] ien_all;

  always_comb begin
    ien_all = '0;
    for (int i = 0; i < NREG; i++) begin
      if (fmode_e'(MODE_MAP[4*i +: 4]) == FM_IEN) ien_all = ien_all | hw_ctl[i*DW +: DW];
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst) !bus_ren |=> $stable(bus_rdata)); // R11
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst) (bus_ren && (int'(bus_addr) >= NREG)) |=> (bus_rdata == '0)); // R11
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) (ien_all == '0) |=> !irq_o); // R10

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    localparam fmode_e M = fmode_e'(MODE_MAP[4*g +: 4]);
    if (M == FM_RV) begin : g_rv
      AST_RV_LIVE: assert property (@(posedge clk) disable iff (rst) (bus_ren && bus_addr == AW'(g)) |=> (bus_rdata == $past(hw_in[g*DW +: DW]))); // R2
    end
    if (M == FM_IEN) begin : g_ien
      AST_IEN_WRITE: assert property (@(posedge clk) disable iff (rst) (bus_wen && bus_addr == AW'(g)) |=> (hw_ctl[g*DW +: DW] == $past(bus_wdata))); // R7
    end
    if (M == FM_STRB) begin : g_stb
      AST_STRB_IDLE: assert property (@(posedge clk) disable iff (rst) !(bus_wen && bus_addr == AW'(g)) |=> (hw_ctl[g*DW +: DW] == '0)); // R8
      AST_STRB_DATA: assert property (@(posedge clk) disable iff (rst) (bus_wen && bus_addr == AW'(g)) |=> (hw_ctl[g*DW +: DW] == $past(bus_wdata))); // R8
    end
  end

endmodule

bind stat_bank stat_bank_chk #(.DW(DW), .NREG(NREG), .AW(AW), .MODE_MAP(MODE_MAP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wen   (bus_wen),
  .bus_ren   (bus_ren),
  .bus_rdata (bus_rdata),
  .hw_in     (hw_in),
  .hw_ctl    (hw_ctl),
  .irq_o     (irq_o)
);

// File: tb/stat_bank_test.sv
`timescale 1ns/1ps
module stat_bank_test;
  localparam int DW = 8;
  localparam int NREG = 13;
  localparam int AW = 4;
  localparam int NV = 55;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_wen = 1'b0;
  logic bus_ren = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic [NREG*DW-1:0] hw_in = '0;
  logic [NREG*DW-1:0] hw_ctl;
  logic irq_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  stat_bank #(.DW(DW), .NREG(NREG), .AW(AW)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wen(bus_wen), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
    .hw_in(hw_in), .hw_ctl(hw_ctl), .irq_o(irq_o)
  );

  // Vector: {req[29:26], hw word[25:22] (F = none), hw value[21:14], op[13:12] 0 idle/1 write/2 read, addr[11:8], data or expected[7:0]}
  localparam logic [29:0] VEC [NV] = '{
    {4'd1,4'h0,8'h3C,2'd0,4'd0,8'h00},  // R1 sampled word
    {4'd1,4'hF,8'h00,2'd2,4'd0,8'h3C},
    {4'd1,4'h0,8'hC3,2'd2,4'd0,8'h3C},
    {4'd1,4'hF,8'h00,2'd2,4'd0,8'hC3},
    {4'd1,4'hF,8'h00,2'd1,4'd0,8'hFF},
    {4'd1,4'hF,8'h00,2'd2,4'd0,8'hC3},
    {4'd2,4'h1,8'h81,2'd2,4'd1,8'h81},  // R2 pass-through
    {4'd2,4'h1,8'h7E,2'd2,4'd1,8'h7E},
    {4'd3,4'h2,8'h01,2'd0,4'd0,8'h00},  // R3 level, read clear
    {4'd3,4'h2,8'h00,2'd0,4'd0,8'h00},
    {4'd3,4'hF,8'h00,2'd2,4'd2,8'h01},
    {4'd3,4'hF,8'h00,2'd2,4'd2,8'h00},
    {4'd3,4'h2,8'h04,2'd2,4'd2,8'h00},
    {4'd3,4'h2,8'h00,2'd2,4'd2,8'h04},
    {4'd3,4'hF,8'h00,2'd2,4'd2,8'h00},
    {4'd3,4'h3,8'hF0,2'd0,4'd0,8'h00},
    {4'd3,4'h3,8'hFF,2'd2,4'd3,8'h0F},
    {4'd3,4'hF,8'h00,2'd2,4'd3,8'h00},
    {4'd4,4'h4,8'h22,2'd0,4'd0,8'h00},  // R4 level, mask clear
    {4'd4,4'h4,8'h00,2'd0,4'd0,8'h00},
    {4'd4,4'hF,8'h00,2'd2,4'd4,8'h22},
    {4'd4,4'hF,8'h00,2'd1,4'd4,8'h02},
    {4'd4,4'hF,8'h00,2'd2,4'd4,8'h20},
    {4'd4,4'hF,8'h00,2'd1,4'd4,8'h00},
    {4'd4,4'hF,8'h00,2'd2,4'd4,8'h20},
    {4'd4,4'h4,8'h40,2'd1,4'd4,8'h40},
    {4'd4,4'h4,8'h00,2'd2,4'd4,8'h60},
    {4'd4,4'h5,8'h7F,2'd0,4'd0,8'h00},
    {4'd4,4'h5,8'hFF,2'd2,4'd5,8'h80},
    {4'd4,4'hF,8'h00,2'd1,4'd5,8'h80},
    {4'd4,4'hF,8'h00,2'd2,4'd5,8'h00},
    {4'd5,4'h6,8'h11,2'd0,4'd0,8'h00},  // R5 edge, read clear
    {4'd5,4'hF,8'h00,2'd2,4'd6,8'h11},
    {4'd5,4'hF,8'h00,2'd2,4'd6,8'h00},
    {4'd5,4'h7,8'hFE,2'd0,4'd0,8'h00},
    {4'd5,4'hF,8'h00,2'd2,4'd7,8'h01},
    {4'd5,4'hF,8'h00,2'd2,4'd7,8'h00},
    {4'd6,4'h8,8'h08,2'd0,4'd0,8'h00},  // R6 edge, mask clear
    {4'd6,4'h8,8'h00,2'd2,4'd8,8'h08},
    {4'd6,4'hF,8'h00,2'd2,4'd8,8'h08},
    {4'd6,4'hF,8'h00,2'd1,4'd8,8'h08},
    {4'd6,4'hF,8'h00,2'd2,4'd8,8'h00},
    {4'd6,4'h9,8'hEF,2'd0,4'd0,8'h00},
    {4'd6,4'hF,8'h00,2'd1,4'd9,8'h00},
    {4'd6,4'hF,8'h00,2'd2,4'd9,8'h10},
    {4'd6,4'hF,8'h00,2'd1,4'd9,8'h10},
    {4'd6,4'hF,8'h00,2'd2,4'd9,8'h00},
    {4'd7,4'hF,8'h00,2'd1,4'd10,8'hA5}, // R7 enable word
    {4'd7,4'hF,8'h00,2'd2,4'd10,8'hA5},
    {4'd8,4'hF,8'h00,2'd1,4'd11,8'h3C}, // R8 strobe word storage
    {4'd8,4'hF,8'h00,2'd2,4'd11,8'h3C},
    {4'd9,4'hF,8'h00,2'd1,4'd12,8'h99}, // R9 written after load
    {4'd9,4'hF,8'h00,2'd2,4'd12,8'h99},
    {4'd11,4'hF,8'h00,2'd2,4'd13,8'h00}, // R11 unmapped
    {4'd11,4'hF,8'h00,2'd2,4'd15,8'h00}
  };

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic idle_bus();
    bus_wen = 1'b0;
    bus_ren = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    bus_addr = a;
    bus_ren = 1'b1;
    @(negedge clk);
    bus_ren = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // Idle levels: latch-low inputs high, falling-edge inputs high, load value on word 12.
    hw_in[3*DW +: DW] = 8'hFF;
    hw_in[5*DW +: DW] = 8'hFF;
    hw_in[7*DW +: DW] = 8'hFF;
    hw_in[9*DW +: DW] = 8'hFF;
    hw_in[12*DW +: DW] = 8'h5A;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R12", "rdata in reset", 32'(bus_rdata), 32'h0);
    check("R12", "irq in reset", 32'(irq_o), 32'h0);
    check("R12", "controls in reset", 32'(hw_ctl[10*DW +: 24]), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R12", "rdata after reset", 32'(bus_rdata), 32'h0);
    hw_in[12*DW +: DW] = 8'h11;  // change after the load edge: must not be taken
    do_read(4'd12);
    check("R9", "load after reset", 32'(bus_rdata), 32'h5A);
    check("R9", "load value on control", 32'(hw_ctl[12*DW +: DW]), 32'h5A);

    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      v = VEC[i];
      if (v[25:22] != 4'hF) hw_in[int'(v[25:22])*DW +: DW] = v[21:14];
      bus_addr = v[11:8];
      bus_wen = (v[13:12] == 2'd1);
      bus_ren = (v[13:12] == 2'd2);
      bus_wdata = (v[13:12] == 2'd1) ? v[7:0] : '0;
      @(negedge clk);
      if (v[13:12] == 2'd2)
        check($sformatf("R%0d", int'(v[29:26])), $sformatf("vector %0d", i), 32'(bus_rdata), 32'(v[7:0]));
    end
    idle_bus();

    check("R7", "enable on control", 32'(hw_ctl[10*DW +: DW]), 32'hA5);
    check("R9", "written value on control", 32'(hw_ctl[12*DW +: DW]), 32'h99);
    check("R8", "no strobe while idle", 32'(hw_ctl[11*DW +: DW]), 32'h0);

    // R8: one-cycle strobe
    bus_addr = 4'd11; bus_wdata = 8'h81; bus_wen = 1'b1;
    @(negedge clk);
    idle_bus();
    check("R8", "strobe after write", 32'(hw_ctl[11*DW +: DW]), 32'h81);
    @(negedge clk);
    check("R8", "strobe gone", 32'(hw_ctl[11*DW +: DW]), 32'h0);

    // R10: gating and latency (enable = A5)
    check("R10", "irq quiet", 32'(irq_o), 32'h0);
    hw_in[6*DW +: DW] = 8'h13;  // rising bit1, not enabled
    repeat (2) @(negedge clk);
    check("R10", "disabled source", 32'(irq_o), 32'h0);
    hw_in[6*DW +: DW] = 8'h17;  // rising bit2, enabled
    @(negedge clk);
    check("R10", "irq one cycle late", 32'(irq_o), 32'h0);
    @(negedge clk);
    check("R10", "irq raised", 32'(irq_o), 32'h1);
    do_read(4'd6);
    check("R5", "edge status read", 32'(bus_rdata), 32'h06);
    check("R10", "irq still high after clearing read", 32'(irq_o), 32'h1);
    @(negedge clk);
    check("R10", "irq dropped", 32'(irq_o), 32'h0);

    // Second reset with a new load value
    rst = 1'b1;
    hw_in[12*DW +: DW] = 8'hC3;
    repeat (2) @(negedge clk);
    check("R12", "enable cleared in reset", 32'(hw_ctl[10*DW +: DW]), 32'h0);
    check("R12", "rdata cleared in reset", 32'(bus_rdata), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    do_read(4'd12);
    check("R9", "reload after second reset", 32'(bus_rdata), 32'hC3);
    do_read(4'd2);
    check("R12", "level word cleared by reset", 32'(bus_rdata), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule